// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus (I2C) that fronts a 512-byte byte-wide memory array and a small bank of configuration registers. The bus lines come in already sampled by the system clock and go out as a single open-drain pull-down enable. Two strap pins give the target's bus address. The memory sits outside the block behind a simple synchronous port: one address, a write strobe with write data, and read data that follows the address by one clock.

The first byte of every transfer selects what the transfer reaches. Type code 1010 opens the memory. Type code 1001 opens the configuration bank. A memory write sets a 9-bit pointer and then gathers up to one 16-byte page into an internal buffer. The buffer is written into the array only when the STOP arrives. The block then reports itself busy for a fixed number of clocks and stays off the bus for that time. Reads stream bytes from the pointer for as long as the controller acknowledges each one. A configuration register is read by a write of its command byte, then a repeated START and a read.

Top module: `i2c_mem_target`

## Requirements
- R1: The first byte after a START is laid out MSB first as type[7:4], strap-match bits [3:2] (bit 3 against `strap_a2`, bit 2 against `strap_a1`), A8 at [1] and R/W at [0], where 1 means read. The block pulls SDA low in the ninth clock only when the type is 1010 or 1001 and both strap bits match. On any other first byte it leaves SDA released until the next START.
- R2: In a memory write (type 1010, R/W=0), bit 1 of the first byte and the next byte together form the 9-bit pointer {A8, byte}. Every byte of the write is acknowledged. The first data byte is stored at that pointer.
- R3: The data bytes of one memory write advance only pointer bits [3:0] and leave bits [8:4] unchanged. A 17th byte wraps to the same page and overwrites the byte written first.
- R4: Written data reaches the memory port (`mem_we`) only after the STOP. A START that comes before the STOP throws away the buffered bytes, and nothing is written.
- R5: A STOP that ends a write carrying at least one data byte holds `busy` high for exactly WR_CYCLES clocks. While `busy` is high the block acknowledges no byte, including its own address.
- R6: A write that carries only the pointer byte and then ends with STOP moves the pointer and does not raise `busy`.
- R7: A memory read (type 1010, R/W=1) sends the byte at the pointer and moves the pointer up by one. It sends the next byte after each controller ACK and releases SDA after a NACK. Bit 1 of a read's first byte is ignored.
- R8: The read pointer counts through the whole 9-bit space and wraps from 0x1FF to 0x000.
- R9: A configuration write (type 1001, R/W=0) is the first byte, a command byte and a data byte. On STOP the data goes into register command[log2(NCFG)-1:0], and the STOP starts the busy period.
- R10: A configuration read is a write of the first byte and the command byte, then a repeated START and a type-1001 read. The selected register comes back MSB first.
- R11: After reset, `sda_oe`, `busy` and `mem_we` are low and every configuration register holds 0x00.
- R12: Read data is taken from `mem_rdata` one clock after `mem_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | When high, pulls SDA low |
| strap_a2 | input | 1 | Bus address strap compared with control bit 3 |
| strap_a1 | input | 1 | Bus address strap compared with control bit 2 |
| busy | output | 1 | Internal write cycle running |
| mem_addr | output | 9 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after the address |

## Verification
The hardest case to reach is a page write that runs past 16 bytes and starts part-way into the page. Only the wrap shows the low-nibble-only advance, and only a read-back of the whole page, at a different pointer, shows which byte was overwritten. The bench writes 17 bytes starting at offset 0xE of one page. It checks that no write strobe has appeared before the STOP. It then sets the pointer to the page base with an address-only write and a repeated START, and streams back all 16 bytes. A second hard case is a START that arrives while the busy period is running. The bench issues a START and an address byte right after a write STOP, before the busy period can end, and expects a NACK.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   localparam int ADDR_W = 9;
   localparam logic [3:0] TYPE_MEM = 4'b1010;
   localparam logic [3:0] TYPE_CFG = 4'b1001;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK
   } bus_st_e;

   typedef enum logic [1:0] {
      PH_CTRL,
      PH_ADDR,
      PH_DATA
   } phase_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("i2c_bus_sync: STAGES must be 2 to 4");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_p  <= scl_sh[STAGES-1];
         sda_p  <= sda_sh[STAGES-1];
      end
   end

   assign scl       = scl_sh[STAGES-1];
   assign sda       = sda_sh[STAGES-1];
   assign scl_rise  = scl & ~scl_p;
   assign scl_fall  = ~scl & scl_p;
   assign start_det = scl & scl_p & sda_p & ~sda;
   assign stop_det  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/i2c_page_buf.sv
module i2c_page_buf #(
   parameter int AW   = 9,
   parameter int PAGE = 16,
   localparam int PB  = $clog2(PAGE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  logic [PB-1:0]   wr_idx,
   input  logic [7:0]      wr_data,
   input  logic            base_set,
   input  logic [AW-PB-1:0] base_in,
   input  logic            commit,
   output logic            any_valid,
   output logic            committing,
   output logic            mem_we,
   output logic [AW-1:0]   mem_waddr,
   output logic [7:0]      mem_wdata
);
   logic [7:0]       data_q [PAGE];
   logic [PAGE-1:0]  valid_q;
   logic [AW-PB-1:0] base_q;
   logic [PB-1:0]    idx_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE; i++) data_q[i] <= '0;
         valid_q <= '0;
         base_q  <= '0;
         idx_q   <= '0;
         run_q   <= 1'b0;
      end else begin
         if (clr) valid_q <= '0;
         if (wr_en) begin
            data_q[wr_idx]  <= wr_data;
            valid_q[wr_idx] <= 1'b1;
         end
         if (base_set) base_q <= base_in;
         if (commit) begin
            run_q <= 1'b1;
            idx_q <= '0;
         end else if (run_q) begin
            idx_q <= idx_q + PB'(1);
            if (idx_q == PB'(PAGE - 1)) begin
               run_q   <= 1'b0;
               valid_q <= '0;
            end
         end
      end
   end

   assign any_valid  = |valid_q;
   assign committing = run_q;
   assign mem_we     = run_q & valid_q[idx_q];
   assign mem_waddr  = {base_q, idx_q};
   assign mem_wdata  = data_q[idx_q];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2c_mem_pkg::*;
#(
   parameter int PAGE        = 16,
   parameter int NCFG        = 4,
   parameter int WR_CYCLES   = 600,
   parameter int SYNC_STAGES = 2,
   localparam int PB  = $clog2(PAGE),
   localparam int CB  = $clog2(NCFG),
   localparam int BCW = $clog2(WR_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              strap_a2,
   input  logic              strap_a1,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   generate
      if (PAGE < 2 || PAGE > 256 || (PAGE & (PAGE - 1)) != 0) begin : g_bad_page
         $error("i2c_mem_target: PAGE must be a power of two from 2 to 256");
      end
      if (NCFG < 2 || NCFG > 256 || (NCFG & (NCFG - 1)) != 0) begin : g_bad_ncfg
         $error("i2c_mem_target: NCFG must be a power of two from 2 to 256");
      end
      if (WR_CYCLES < PAGE + 1) begin : g_bad_wr
         $error("i2c_mem_target: WR_CYCLES must exceed PAGE");
      end
   endgenerate

   // bus sampling and condition detection
   logic scl, scl_rise, scl_fall, sda, start_det, stop_det;

   i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl      (scl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda      (sda),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   // protocol state
   bus_st_e           st;
   phase_e            ph;
   logic [3:0]        cnt;
   logic [7:0]        shreg;
   logic              is_cfg, rw, a8_q, mack;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        cmd;
   logic              cfg_pend;
   logic [7:0]        cfg_wdata;
   logic [7:0]        cfg_q [NCFG];
   logic [BCW-1:0]    busy_cnt;

   logic [CB-1:0]     cidx;
   logic [7:0]        tx_next;
   logic              byte_done, ctrl_match, go;
   logic [ADDR_W-1:0] new_ptr;

   assign busy       = (busy_cnt != '0);
   assign go         = ~busy & ~start_det & ~stop_det;
   assign cidx       = cmd[CB-1:0];
   assign tx_next    = is_cfg ? cfg_q[cidx] : mem_rdata;
   assign byte_done  = go & (st == ST_RX) & scl_fall & (cnt == 4'd8);
   assign ctrl_match = ((shreg[7:4] == TYPE_MEM) || (shreg[7:4] == TYPE_CFG)) &&
                       (shreg[3:2] == {strap_a2, strap_a1});
   assign new_ptr    = {a8_q, shreg};

   // page buffer and commit sequencer
   logic buf_we, buf_base, buf_clr, buf_commit, buf_any, committing;
   logic [ADDR_W-1:0] buf_waddr;

   assign buf_we     = byte_done & (ph == PH_DATA) & ~is_cfg;
   assign buf_base   = byte_done & (ph == PH_ADDR) & ~is_cfg;
   assign buf_clr    = start_det & ~busy;
   assign buf_commit = stop_det & ~busy & buf_any;

   i2c_page_buf #(.AW(ADDR_W), .PAGE(PAGE)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .wr_en     (buf_we),
      .wr_idx    (ptr[PB-1:0]),
      .wr_data   (shreg),
      .base_set  (buf_base),
      .base_in   (new_ptr[ADDR_W-1:PB]),
      .commit    (buf_commit),
      .any_valid (buf_any),
      .committing(committing),
      .mem_we    (mem_we),
      .mem_waddr (buf_waddr),
      .mem_wdata (mem_wdata)
   );

   assign mem_addr = committing ? buf_waddr : ptr;
   assign sda_oe   = (st == ST_ACK) || ((st == ST_TX) && !shreg[7]);

   // internal write cycle timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt - BCW'(1);
      end else if (stop_det && (buf_any || cfg_pend)) begin
         busy_cnt <= BCW'(WR_CYCLES);
      end
   end

   // byte-level protocol engine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_CTRL;
         cnt       <= '0;
         shreg     <= '0;
         is_cfg    <= 1'b0;
         rw        <= 1'b0;
         a8_q      <= 1'b0;
         mack      <= 1'b0;
         ptr       <= '0;
         cmd       <= '0;
         cfg_pend  <= 1'b0;
         cfg_wdata <= '0;
         for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
      end else if (busy) begin
         st <= ST_IDLE;
      end else if (start_det) begin
         st       <= ST_RX;
         ph       <= PH_CTRL;
         cnt      <= '0;
         cfg_pend <= 1'b0;
      end else if (stop_det) begin
         st       <= ST_IDLE;
         cfg_pend <= 1'b0;
         if (cfg_pend) cfg_q[cidx] <= cfg_wdata;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise) begin
                  shreg <= {shreg[6:0], sda};
                  cnt   <= cnt + 4'd1;
               end else if (byte_done) begin
                  cnt <= '0;
                  st  <= ST_ACK;
                  case (ph)
                     PH_CTRL: begin
                        if (ctrl_match) begin
                           is_cfg <= (shreg[7:4] == TYPE_CFG);
                           rw     <= shreg[0];
                           if (shreg[7:4] == TYPE_MEM && !shreg[0]) a8_q <= shreg[1];
                           ph     <= PH_ADDR;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_ADDR: begin
                        ph <= PH_DATA;
                        if (is_cfg) cmd <= shreg;
                        else        ptr <= new_ptr;
                     end
                     default: begin
                        if (is_cfg) begin
                           cfg_pend  <= 1'b1;
                           cfg_wdata <= shreg;
                        end else begin
                           ptr[PB-1:0] <= ptr[PB-1:0] + PB'(1);
                        end
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     shreg <= tx_next;
                     if (!is_cfg) ptr <= ptr + ADDR_W'(1);
                     st <= ST_TX;
                  end else begin
                     st <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     st <= ST_TXACK;
                  end else begin
                     shreg <= {shreg[6:0], 1'b0};
                     cnt   <= cnt + 4'd1;
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise) begin
                  mack <= ~sda;
               end else if (scl_fall) begin
                  cnt <= '0;
                  if (mack) begin
                     shreg <= tx_next;
                     if (!is_cfg) ptr <= ptr + ADDR_W'(1);
                     st <= ST_TX;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // assertions
   p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl)
      else $error("SDA pulled low while SCL high");

   p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy)
      else $error("memory write outside internal write cycle");

   p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det))
      else $error("busy started without STOP");

   p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe)
      else $error("bus driven during write cycle");
endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
   localparam int Q  = 10;
   localparam int WC = 600;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic sda_oe, busy, mem_we;
   logic [8:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   wire  sda_line = sda_drv & ~sda_oe;

   always #4 clk = ~clk;

   i2c_mem_target i_i2c_mem_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_a2(1'b1), .strap_a1(1'b0), .busy(busy),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   logic [7:0] mem [512];
   logic [7:0] ref_mem [512];
   int n_cmp = 0, n_bad = 0, busy_cycles = 0, we_seen = 0;
   item_t exp_q[$];
   logic [7:0] act_q[$];

   initial for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
   end

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   always @(negedge clk) begin
      if (busy) busy_cycles++;
      if (mem_we) we_seen++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
         logic [7:0] a;
         a = act_q.pop_front();
         if (exp_q.size() == 0) chk("scoreboard-empty", a, -1);
         else begin
            item_t e;
            e = exp_q.pop_front();
            chk(e.tag, a, e.val);
         end
      end
   end

   task automatic hq(input int n); repeat (n) @(negedge clk); endtask

   task automatic i2c_start;
      sda_drv = 1; hq(Q); scl_drv = 1; hq(Q); sda_drv = 0; hq(Q); scl_drv = 0; hq(Q);
   endtask

   task automatic i2c_stop;
      sda_drv = 0; hq(Q); scl_drv = 1; hq(Q); sda_drv = 1; hq(Q);
   endtask

   task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
      logic ack;
      for (int i = 7; i >= 0; i--) begin
         sda_drv = b[i]; hq(Q); scl_drv = 1; hq(2 * Q); scl_drv = 0; hq(Q);
      end
      sda_drv = 1; hq(Q); scl_drv = 1; hq(Q);
      ack = ~sda_line;
      hq(Q); scl_drv = 0; hq(Q);
      chk(tag, ack, exp_ack);
   endtask

   task automatic recv(input logic ack_it);
      logic [7:0] b;
      sda_drv = 1;
      for (int i = 7; i >= 0; i--) begin
         hq(Q); scl_drv = 1; hq(Q); b[i] = sda_line; hq(Q); scl_drv = 0;
      end
      hq(Q); sda_drv = ~ack_it; hq(Q); scl_drv = 1; hq(2 * Q); scl_drv = 0; hq(Q); sda_drv = 1;
      act_q.push_back(b);
   endtask

   function automatic logic [7:0] ctl(input logic [3:0] t, input logic a8, input logic rd);
      return {t, 2'b10, a8, rd};
   endfunction

   task automatic expect_mem(input int addr, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         item_t e;
         e.val = ref_mem[(addr + k) % 512];
         e.tag = tag;
         exp_q.push_back(e);
      end
   endtask

   task automatic read_mem(input int addr, input int n, input string tag);
      expect_mem(addr, n, tag);
      i2c_start;
      send(ctl(4'b1010, addr[8], 1'b0), 1'b1, tag);
      send(addr[7:0], 1'b1, tag);
      i2c_start;
      send(ctl(4'b1010, ~addr[8], 1'b1), 1'b1, tag);
      for (int k = 0; k < n; k++) recv(k < n - 1);
      i2c_stop;
   endtask

   task automatic read_cfg(input logic [7:0] c, input logic [7:0] v, input string tag);
      item_t e;
      e.val = v; e.tag = tag; exp_q.push_back(e);
      i2c_start;
      send(ctl(4'b1001, 1'b0, 1'b0), 1'b1, tag);
      send(c, 1'b1, tag);
      i2c_start;
      send(ctl(4'b1001, 1'b0, 1'b1), 1'b1, tag);
      recv(1'b0);
      i2c_stop;
   endtask

   task automatic wait_idle; while (busy) @(negedge clk); hq(4); endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary;
      $finish;
   end

   initial begin
      hq(5); rst_n = 1; hq(5);
      // R11 reset state
      chk("R11 sda_oe", sda_oe, 0);
      chk("R11 busy", busy, 0);
      chk("R11 mem_we", mem_we, 0);

      // R1 address mismatch and wrong type
      i2c_start; send(8'b1010_01_0_0, 1'b0, "R1 strap mismatch"); i2c_stop;
      i2c_start; send(8'b1100_10_0_0, 1'b0, "R1 wrong type"); i2c_stop;
      hq(5); chk("R1 no busy", busy, 0);

      // R2 single write at 0x125, R5 busy behaviour
      i2c_start;
      send(ctl(4'b1010, 1'b1, 1'b0), 1'b1, "R2 ctrl");
      send(8'h25, 1'b1, "R2 addr");
      send(8'h5A, 1'b1, "R2 data");
      ref_mem[9'h125] = 8'h5A;
      busy_cycles = 0;
      i2c_stop;
      chk("R5 busy after stop", busy, 1);
      i2c_start; send(ctl(4'b1010, 1'b0, 1'b0), 1'b0, "R5 nack while busy"); i2c_stop;
      wait_idle;
      chk("R5 busy length", busy_cycles, WC);

      // R6 address-only write then current-address read
      i2c_start;
      send(ctl(4'b1010, 1'b1, 1'b0), 1'b1, "R6 ctrl");
      send(8'h25, 1'b1, "R6 addr");
      i2c_stop; hq(5);
      chk("R6 no busy", busy, 0);
      expect_mem(9'h125, 1, "R6/R2 current read");
      i2c_start; send(ctl(4'b1010, 1'b0, 1'b1), 1'b1, "R7 read ctrl"); recv(1'b0); i2c_stop;

      // R3 page write wrapping from offset 0xE, R4 no write before stop
      we_seen = 0;
      i2c_start;
      send(ctl(4'b1010, 1'b0, 1'b0), 1'b1, "R3 ctrl");
      send(8'h4E, 1'b1, "R3 addr");
      for (int k = 0; k < 17; k++) begin
         send(8'h80 + 8'(k), 1'b1, "R3 data");
         ref_mem[9'h040 + ((14 + k) % 16)] = 8'h80 + 8'(k);
      end
      chk("R4 no write before stop", we_seen, 0);
      i2c_stop;
      wait_idle;
      read_mem(9'h040, 16, "R3/R7/R12 page readback");

      // R4 START before STOP discards
      i2c_start;
      send(ctl(4'b1010, 1'b0, 1'b0), 1'b1, "R4 ctrl");
      send(8'h10, 1'b1, "R4 addr");
      send(8'hEE, 1'b1, "R4 data");
      i2c_start; i2c_stop; hq(5);
      chk("R4 no busy after discard", busy, 0);
      read_mem(9'h010, 1, "R4 unchanged");

      // R8 pointer wrap
      read_mem(9'h1FE, 3, "R8 wrap");

      // R9 config write, R10 config read
      i2c_start;
      send(ctl(4'b1001, 1'b1, 1'b0), 1'b1, "R9 ctrl");
      send(8'h02, 1'b1, "R9 cmd");
      send(8'h3C, 1'b1, "R9 data");
      i2c_stop;
      chk("R9 busy", busy, 1);
      wait_idle;
      read_cfg(8'h02, 8'h3C, "R10 read back");
      read_cfg(8'h06, 8'h3C, "R9 low command bits");
      read_cfg(8'h01, 8'h00, "R11 cfg reset");

      hq(20);
      chk("scoreboard drained", exp_q.size(), 0);
      summary;
      $finish;
   end
endmodule